// File: doc/BRIEF.md
# Synchronous DRAM Column Burst Engine with Clock Suspend

This block is the memory-side core of a small synchronous DRAM-style device. It decodes a two-bit command bus carrying column READ and WRITE commands with a bank and column address. It runs fixed-length column bursts against a register-file array that stands in for the storage cells. Read data is returned after a fixed latency on a split data bus made of `dq_out` and `dq_oe`. Write data is taken from `dq_in`, one word per internal cycle.

A clock-enable input lets the memory controller freeze the device in the middle of a burst. The core registers the enable on every rising edge. While a burst is running, a low sample suppresses the next internal edge. On a suppressed edge the column counter, the latency count, the output word, the output enable and the storage contents all keep their values, and anything present on the command and data inputs is dropped. When the device is idle, a low sample simply makes that edge a no-operation.

Top module: `sdram_burst_core`

## Requirements
- R1: A WRITE command (cmd = 2'b10) stores `dq_in` at the addressed column on the accepting edge. The next three internal edges store the following words at column offsets +1, +2 and +3. The offset wraps within the aligned block of four columns.
- R2: For a READ command (cmd = 2'b01), the first word appears on `dq_out` with `dq_oe` high after the second internal edge that follows the accepting edge. The remaining words follow one per internal edge, in the same wrapping column order. `dq_oe` falls on the internal edge after the fourth word.
- R3: If `cke` is low at an edge while a burst is in progress, that edge still runs normally. The next edge is suppressed, so the burst position does not advance on it.
- R4: Across a suppressed edge, `dq_out` and `dq_oe` keep their values.
- R5: Commands and `dq_in` data present at a suppressed edge are ignored.
- R6: A high `cke` sample ends the suspension, and operation resumes on the following edge.
- R7: With no burst in progress, an edge at which `cke` is low is a no-operation: no command is accepted and no suspension follows.
- R8: READ and WRITE commands that arrive while a burst (including its read latency) is in progress are ignored.
- R9: Reset (active-low `rst_n`, asynchronous) forces `dq_oe` and `dq_out` to zero and abandons any burst.
- R10: Command code 2'b11, like 2'b00, is a no-operation.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Device clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cke | input | 1 | Clock enable sampled on each rising edge |
| cmd | input | 2 | 00 NOP, 01 READ, 10 WRITE, 11 NOP |
| bank | input | $clog2(NBANK) | Bank address for READ/WRITE |
| col | input | $clog2(NCOL) | Starting column address |
| dq_in | input | DW | Write data from the pads |
| dq_out | output | DW | Read data to the pads |
| dq_oe | output | 1 | High while read data words are valid |

## Verification
The bench builds the core with its defaults: two banks of sixteen 16-bit columns, a burst of four and a read latency of two. With these values, a start column of 6 or 2 forces the wrap inside the aligned four-column block. Both the write and read traffic can be checked word by word against hand-computed values. The short latency lets single and double suspensions land on the latency cycles, the data cycles and the write cycles, each within a few clocks, and also lets a burst be cut off by reset.

// File: rtl/sdr_pkg.sv
package sdr_pkg;
  typedef enum logic [1:0] {
    CMD_NOP  = 2'b00,
    CMD_RD   = 2'b01,
    CMD_WR   = 2'b10,
    CMD_NOP3 = 2'b11
  } cmd_e;
endpackage

// File: rtl/sdr_suspend_gate.sv
// Registers the clock enable and produces the internal edge enable.
module sdr_suspend_gate (
  input  logic clk,
  input  logic rst_n,
  input  logic cke,
  input  logic busy,
  output logic susp,
  output logic ien
);
  logic susp_q, susp_d;

  // A low sample during a burst freezes the following edge (R3, R6)
  always_comb susp_d = !cke && busy;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) susp_q <= 1'b0;
    else        susp_q <= susp_d;
  end

  assign susp = susp_q;
  assign ien  = !susp_q;
endmodule

// File: rtl/sdr_cell_array.sv
// Register-file stand-in for the storage cells: one write port, one read port.
module sdr_cell_array #(
  parameter int NBANK = 2,
  parameter int NCOL  = 16,
  parameter int DW    = 16,
  localparam int BW   = $clog2(NBANK),
  localparam int CW   = $clog2(NCOL),
  localparam int NW   = NBANK * NCOL
) (
  input  logic          clk,
  input  logic          we,
  input  logic [BW-1:0] wbank,
  input  logic [CW-1:0] wcol,
  input  logic [DW-1:0] wdata,
  input  logic [BW-1:0] rbank,
  input  logic [CW-1:0] rcol,
  output logic [DW-1:0] rdata
);
  logic [DW-1:0] cells [NW];

  always_ff @(posedge clk) begin
    if (we) cells[{wbank, wcol}] <= wdata;
  end

  assign rdata = cells[{rbank, rcol}];
endmodule

// File: rtl/sdr_burst_seq.sv
// Command decode, burst position and read latency, all advanced only on internal edges.
module sdr_burst_seq #(
  parameter int NBANK = 2,
  parameter int NCOL  = 16,
  parameter int BL    = 4,
  parameter int CL    = 2,
  localparam int BW   = $clog2(NBANK),
  localparam int CW   = $clog2(NCOL),
  localparam int OW   = $clog2(BL),
  localparam int SW   = $clog2(CL + BL + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ien,
  input  logic          cke,
  input  logic [1:0]    cmd,
  input  logic [BW-1:0] bank,
  input  logic [CW-1:0] col,
  output logic          busy,
  output logic          mem_we,
  output logic [BW-1:0] mem_wbank,
  output logic [CW-1:0] mem_wcol,
  output logic [BW-1:0] mem_rbank,
  output logic [CW-1:0] mem_rcol,
  output logic          rd_load,
  output logic          rd_end
);
  import sdr_pkg::*;

  logic          busy_q, busy_d;
  logic          wr_q, wr_d;
  logic [BW-1:0] bank_q, bank_d;
  logic [CW-1:0] col_q, col_d;
  logic [SW-1:0] step_q, step_d;

  logic          is_rd, is_wr, accept;
  logic [SW-1:0] rel;
  logic [OW-1:0] woff, roff;

  // R7, R8, R10: only an idle, enabled edge with a high sample takes READ/WRITE
  assign is_rd  = (cmd == CMD_RD);
  assign is_wr  = (cmd == CMD_WR);
  assign accept = ien && cke && !busy_q && (is_rd || is_wr);

  assign rel  = step_q - SW'(CL);
  assign woff = col_q[OW-1:0] + step_q[OW-1:0];
  assign roff = col_q[OW-1:0] + rel[OW-1:0];

  // Write port: first word with the command, then one word per internal edge (R1)
  always_comb begin
    mem_we    = ien && ((accept && is_wr) || (busy_q && wr_q));
    mem_wbank = accept ? bank : bank_q;
    mem_wcol  = accept ? col  : {col_q[CW-1:OW], woff};
  end

  // Read side: words after CL internal edges, then release (R2)
  always_comb begin
    mem_rbank = bank_q;
    mem_rcol  = {col_q[CW-1:OW], roff};
    rd_load   = ien && busy_q && !wr_q &&
                (step_q >= SW'(CL)) && (step_q < SW'(CL + BL));
    rd_end    = ien && busy_q && !wr_q && (step_q == SW'(CL + BL));
  end

  always_comb begin
    busy_d = busy_q;
    wr_d   = wr_q;
    bank_d = bank_q;
    col_d  = col_q;
    step_d = step_q;
    if (accept) begin
      busy_d = 1'b1;
      wr_d   = is_wr;
      bank_d = bank;
      col_d  = col;
      step_d = SW'(1);
    end else if (ien && busy_q) begin
      // R3/R5: nothing here moves on a suppressed edge
      step_d = step_q + SW'(1);
      if ((wr_q && step_q == SW'(BL - 1)) || (!wr_q && step_q == SW'(CL + BL)))
        busy_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      wr_q   <= 1'b0;
      bank_q <= '0;
      col_q  <= '0;
      step_q <= '0;
    end else begin
      busy_q <= busy_d;
      wr_q   <= wr_d;
      bank_q <= bank_d;
      col_q  <= col_d;
      step_q <= step_d;
    end
  end

  assign busy = busy_q;
endmodule

// File: rtl/sdram_burst_core.sv
module sdram_burst_core #(
  parameter int NBANK = 2,
  parameter int NCOL  = 16,
  parameter int DW    = 16,
  parameter int BL    = 4,
  parameter int CL    = 2,
  localparam int BW   = $clog2(NBANK),
  localparam int CW   = $clog2(NCOL)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cke,
  input  logic [1:0]    cmd,
  input  logic [BW-1:0] bank,
  input  logic [CW-1:0] col,
  input  logic [DW-1:0] dq_in,
  output logic [DW-1:0] dq_out,
  output logic          dq_oe
);
  logic          susp, ien, burst_busy;
  logic          mem_we, rd_load, rd_end;
  logic [BW-1:0] mem_wbank, mem_rbank;
  logic [CW-1:0] mem_wcol, mem_rcol;
  logic [DW-1:0] mem_rdata;
  logic [DW-1:0] dq_q, dq_d;
  logic          oe_q, oe_d;

  sdr_suspend_gate u_gate (
    .clk   (clk),
    .rst_n (rst_n),
    .cke   (cke),
    .busy  (burst_busy),
    .susp  (susp),
    .ien   (ien)
  );

  sdr_burst_seq #(.NBANK(NBANK), .NCOL(NCOL), .BL(BL), .CL(CL)) u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .ien       (ien),
    .cke       (cke),
    .cmd       (cmd),
    .bank      (bank),
    .col       (col),
    .busy      (burst_busy),
    .mem_we    (mem_we),
    .mem_wbank (mem_wbank),
    .mem_wcol  (mem_wcol),
    .mem_rbank (mem_rbank),
    .mem_rcol  (mem_rcol),
    .rd_load   (rd_load),
    .rd_end    (rd_end)
  );

  sdr_cell_array #(.NBANK(NBANK), .NCOL(NCOL), .DW(DW)) u_cells (
    .clk   (clk),
    .we    (mem_we),
    .wbank (mem_wbank),
    .wcol  (mem_wcol),
    .wdata (dq_in),
    .rbank (mem_rbank),
    .rcol  (mem_rcol),
    .rdata (mem_rdata)
  );

  // Output stage: loads only on internal edges, so a suspend holds it (R4)
  always_comb begin
    dq_d = dq_q;
    oe_d = oe_q;
    if (rd_load) begin
      dq_d = mem_rdata;
      oe_d = 1'b1;
    end else if (rd_end) begin
      oe_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dq_q <= '0;
      oe_q <= 1'b0;
    end else begin
      dq_q <= dq_d;
      oe_q <= oe_d;
    end
  end

  assign dq_out = dq_q;
  assign dq_oe  = oe_q;
endmodule

// File: rtl/sdram_burst_core_chk.sv
module sdram_burst_core_chk #(
  parameter int DW = 16,
  parameter int BL = 4
) (
  input logic          clk,
  input logic          rst_n,
  input logic          cke,
  input logic          susp,
  input logic          busy,
  input logic          dq_oe,
  input logic [DW-1:0] dq_out
);
  localparam int RW = $clog2(BL + 2);
  logic [RW-1:0] oe_run;

  // Internal edges seen with the output enabled
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          oe_run <= '0;
    else if (!dq_oe)     oe_run <= '0;
    else if (!susp)      oe_run <= oe_run + RW'(1);
  end

  assert_oe_window_R2: assert property (@(posedge clk) disable iff (!rst_n)
    oe_run <= RW'(BL));

  assert_oe_in_burst_R2: assert property (@(posedge clk) disable iff (!rst_n)
    dq_oe |-> busy);

  assert_frozen_out_R4: assert property (@(posedge clk) disable iff (!rst_n)
    susp |=> ($stable(dq_oe) && $stable(dq_out)));

  assert_frozen_burst_R5: assert property (@(posedge clk) disable iff (!rst_n)
    susp |=> $stable(busy));

  assert_idle_nop_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !cke) |=> (!busy && !susp));
endmodule

bind sdram_burst_core sdram_burst_core_chk #(.DW(DW), .BL(BL)) u_chk (
  .clk    (clk),
  .rst_n  (rst_n),
  .cke    (cke),
  .susp   (susp),
  .busy   (burst_busy),
  .dq_oe  (dq_oe),
  .dq_out (dq_out)
);

// File: tb/sdram_burst_core_bench.sv
module sdram_burst_core_bench;
  logic        clk;
  logic        rst_n;
  logic        cke;
  logic [1:0]  cmd;
  logic        bank;
  logic [3:0]  col;
  logic [15:0] dq_in;
  logic [15:0] dq_out;
  logic        dq_oe;

  int errors = 0;
  int checks = 0;
  bit done   = 0;

  sdram_burst_core u_sdram_burst_core (
    .clk    (clk),
    .rst_n  (rst_n),
    .cke    (cke),
    .cmd    (cmd),
    .bank   (bank),
    .col    (col),
    .dq_in  (dq_in),
    .dq_out (dq_out),
    .dq_oe  (dq_oe)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  typedef struct packed {
    logic        cke;
    logic [1:0]  cmd;
    logic        bank;
    logic [3:0]  col;
    logic [15:0] din;
    logic        eoe;
    logic [15:0] edq;
    logic [3:0]  rq;
  } vec_t;

  // Row i: inputs before edge i, expected outputs after edge i
  localparam int NV = 37;
  localparam vec_t VEC [NV] = '{
    '{1'b1, 2'd2, 1'b0, 4'd4, 16'hA0A0, 1'b0, 16'h0000, 4'd1},  // 0  R1 write b0 c4
    '{1'b1, 2'd0, 1'b0, 4'd0, 16'hA0A1, 1'b0, 16'h0000, 4'd1},  // 1  R1
    '{1'b1, 2'd0, 1'b0, 4'd0, 16'hA0A2, 1'b0, 16'h0000, 4'd1},  // 2  R1
    '{1'b1, 2'd0, 1'b0, 4'd0, 16'hA0A3, 1'b0, 16'h0000, 4'd1},  // 3  R1
    '{1'b1, 2'd1, 1'b0, 4'd6, 16'h0000, 1'b0, 16'h0000, 4'd2},  // 4  R2 read b0 c6
    '{1'b1, 2'd0, 1'b0, 4'd0, 16'h0000, 1'b0, 16'h0000, 4'd2},  // 5  R2 latency
    '{1'b1, 2'd0, 1'b0, 4'd0, 16'h0000, 1'b1, 16'hA0A2, 4'd2},  // 6  R2 word c6
    '{1'b0, 2'd0, 1'b0, 4'd0, 16'h0000, 1'b1, 16'hA0A3, 4'd3},  // 7  R3 low edge still runs
    '{1'b1, 2'd0, 1'b0, 4'd0, 16'h0000, 1'b1, 16'hA0A3, 4'd4},  // 8  R4 held
    '{1'b1, 2'd0, 1'b0, 4'd0, 16'h0000, 1'b1, 16'hA0A0, 4'd6},  // 9  R6 resumes, wrap to c4
    '{1'b0, 2'd0, 1'b0, 4'd0, 16'h0000, 1'b1, 16'hA0A1, 4'd3},  // 10 R3
    '{1'b0, 2'd0, 1'b0, 4'd0, 16'h0000, 1'b1, 16'hA0A1, 4'd4},  // 11 R4
    '{1'b1, 2'd1, 1'b1, 4'd0, 16'h0000, 1'b1, 16'hA0A1, 4'd5},  // 12 R5 read dropped
    '{1'b1, 2'd0, 1'b0, 4'd0, 16'h0000, 1'b0, 16'h0000, 4'd2},  // 13 R2 release
    '{1'b0, 2'd2, 1'b0, 4'd4, 16'hFFFF, 1'b0, 16'h0000, 4'd7},  // 14 R7 idle low: no write
    '{1'b1, 2'd2, 1'b1, 4'd2, 16'hB0B0, 1'b0, 16'h0000, 4'd1},  // 15 R1 write b1 c2
    '{1'b0, 2'd0, 1'b0, 4'd0, 16'hB0B1, 1'b0, 16'h0000, 4'd3},  // 16 R3 c3 written
    '{1'b1, 2'd0, 1'b0, 4'd0, 16'hDEAD, 1'b0, 16'h0000, 4'd5},  // 17 R5 data dropped
    '{1'b1, 2'd0, 1'b0, 4'd0, 16'hB0B2, 1'b0, 16'h0000, 4'd6},  // 18 R6 c0
    '{1'b1, 2'd2, 1'b0, 4'd0, 16'hB0B3, 1'b0, 16'h0000, 4'd8},  // 19 R8 write cmd ignored, c1
    '{1'b1, 2'd1, 1'b1, 4'd0, 16'h0000, 1'b0, 16'h0000, 4'd2},  // 20 R2 read b1 c0
    '{1'b1, 2'd0, 1'b0, 4'd0, 16'h0000, 1'b0, 16'h0000, 4'd2},  // 21
    '{1'b1, 2'd0, 1'b0, 4'd0, 16'h0000, 1'b1, 16'hB0B2, 4'd5},  // 22 R5 not DEAD
    '{1'b1, 2'd0, 1'b0, 4'd0, 16'h0000, 1'b1, 16'hB0B3, 4'd8},  // 23 R8
    '{1'b1, 2'd0, 1'b0, 4'd0, 16'h0000, 1'b1, 16'hB0B0, 4'd1},  // 24 R1
    '{1'b1, 2'd0, 1'b0, 4'd0, 16'h0000, 1'b1, 16'hB0B1, 4'd3},  // 25 R3
    '{1'b1, 2'd0, 1'b0, 4'd0, 16'h0000, 1'b0, 16'h0000, 4'd2},  // 26 R2
    '{1'b1, 2'd1, 1'b0, 4'd4, 16'h0000, 1'b0, 16'h0000, 4'd7},  // 27 read b0 c4
    '{1'b1, 2'd0, 1'b0, 4'd0, 16'h0000, 1'b0, 16'h0000, 4'd2},  // 28
    '{1'b1, 2'd0, 1'b0, 4'd0, 16'h0000, 1'b1, 16'hA0A0, 4'd7},  // 29 R7 not FFFF
    '{1'b1, 2'd0, 1'b0, 4'd0, 16'h0000, 1'b1, 16'hA0A1, 4'd2},  // 30
    '{1'b1, 2'd0, 1'b0, 4'd0, 16'h0000, 1'b1, 16'hA0A2, 4'd2},  // 31
    '{1'b1, 2'd0, 1'b0, 4'd0, 16'h0000, 1'b1, 16'hA0A3, 4'd2},  // 32
    '{1'b1, 2'd0, 1'b0, 4'd0, 16'h0000, 1'b0, 16'h0000, 4'd5},  // 33 R5 dropped read never ran
    '{1'b1, 2'd3, 1'b0, 4'd0, 16'h0000, 1'b0, 16'h0000, 4'd10}, // 34 R10 code 11
    '{1'b1, 2'd0, 1'b0, 4'd0, 16'h0000, 1'b0, 16'h0000, 4'd10}, // 35 R10
    '{1'b1, 2'd0, 1'b0, 4'd0, 16'h0000, 1'b0, 16'h0000, 4'd10}  // 36 R10 no data
  };

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic drive(input logic c, input logic [1:0] k, input logic b,
                       input logic [3:0] a, input logic [15:0] d);
    @(negedge clk);
    cke = c; cmd = k; bank = b; col = a; dq_in = d;
    @(posedge clk);
    #1;
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; cke = 1'b1; cmd = 2'd0; bank = 1'b0; col = 4'd0; dq_in = 16'h0;
    repeat (3) @(posedge clk);
    #1;
    chk("R9 reset oe", {15'd0, dq_oe}, 16'd0);
    chk("R9 reset dq", dq_out, 16'h0000);
    @(negedge clk);
    rst_n = 1'b1;

    for (int i = 0; i < NV; i++) begin
      drive(VEC[i].cke, VEC[i].cmd, VEC[i].bank, VEC[i].col, VEC[i].din);
      chk($sformatf("R%0d row %0d oe", VEC[i].rq, i), {15'd0, dq_oe}, {15'd0, VEC[i].eoe});
      if (VEC[i].eoe)
        chk($sformatf("R%0d row %0d dq", VEC[i].rq, i), dq_out, VEC[i].edq);
    end

    // R9: reset in the middle of a read burst
    drive(1'b1, 2'd1, 1'b0, 4'd4, 16'h0);
    drive(1'b1, 2'd0, 1'b0, 4'd0, 16'h0);
    drive(1'b1, 2'd0, 1'b0, 4'd0, 16'h0);
    chk("R9 pre-reset word", dq_out, 16'hA0A0);
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    chk("R9 async oe", {15'd0, dq_oe}, 16'd0);
    chk("R9 async dq", dq_out, 16'h0000);
    @(negedge clk);
    rst_n = 1'b1;
    for (int j = 0; j < 4; j++) begin
      drive(1'b1, 2'd0, 1'b0, 4'd0, 16'h0);
      chk("R9 burst abandoned", {15'd0, dq_oe}, 16'd0);
    end

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule